// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block turns asynchronous pin activity into interrupt requests for a processor core. A dedicated interrupt pin has four sense modes. It can request while the pin is held low, or it can request on any transition, on a falling transition or on a rising transition. A separate group of general-purpose pins shares one change request. Any pin whose mask bit is set can raise that request, but only while the group's global enable is on.

Every pin passes through a two-flop synchronizer. A further register holds the previous synchronized value, and transitions are found by comparing the two. In the three edge modes, and for the pin group, a qualified transition sets a sticky pending flag. The flag stays set until software pulses the matching clear input. In low-level mode the dedicated request follows the synchronized pin directly and no flag is stored. The control fields are plain inputs that a register file elsewhere drives.

Top module: `ext_irq_unit`

## Requirements
- R1: While reset is asserted and just after it is released, with all pins low, both requests and both pending flags are 0.
- R2: With sense code 2'b00, `ext_req_o` equals `ext_en_i` AND the inverted pin, two clock edges behind the pin. The pending flag never sets in this mode.
- R3: With sense code 2'b01, every transition of the dedicated pin sets `ext_pend_o`. `ext_req_o` is `ext_en_i` AND `ext_pend_o` in every edge mode.
- R4: With sense code 2'b10, only a high-to-low transition sets `ext_pend_o`, and a rising transition has no effect.
- R5: With sense code 2'b11, only a low-to-high transition sets `ext_pend_o`, and a falling transition has no effect.
- R6: While `ext_en_i` is 0, no transition sets `ext_pend_o`, and `ext_req_o` stays 0.
- R7: A transition on group pin i sets `grp_pend_o` when `grp_en_i` is 1 and `grp_mask_i[i]` is 1. `grp_req_o` is `grp_en_i` AND `grp_pend_o`.
- R8: A transition on a group pin whose mask bit is 0, or any transition while `grp_en_i` is 0, leaves `grp_pend_o` unchanged.
- R9: A clear strobe held for one cycle drops its pending flag at the next edge. If a qualifying event arrives in the same cycle as the clear, the flag stays set.
- R10: A pin transition applied between edges k-1 and k sets the pending flag at edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | Dedicated interrupt pin, asynchronous |
| grp_pin_i | input | NPINS | Group pins, asynchronous |
| sense_mode_i | input | 2 | Dedicated pin sense code: 00 low level, 01 any edge, 10 falling, 11 rising |
| ext_en_i | input | 1 | Dedicated pin request enable |
| grp_en_i | input | 1 | Global enable for the pin group |
| grp_mask_i | input | NPINS | Per-pin enable for the group |
| ext_clr_i | input | 1 | Clear strobe for the dedicated pending flag |
| grp_clr_i | input | 1 | Clear strobe for the group pending flag |
| ext_req_o | output | 1 | Dedicated pin interrupt request |
| grp_req_o | output | 1 | Group pin-change interrupt request |
| ext_pend_o | output | 1 | Dedicated pin pending flag |
| grp_pend_o | output | 1 | Group pending flag |

## Verification
The hardest case to reach from the ports is a clear strobe that coincides with a new event. The event only becomes visible inside the block two edges after the pin moves, so a clear aligned with the pin change misses it. The bench toggles a pin and then holds the clear high across the whole synchronizer delay, which makes the event and the clear overlap in one cycle. A pseudo-random stream then switches sense codes while flags are still pending, so that leftover state from an edge mode meets a level-mode request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i <= STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o    = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/ext_sense.sv
module ext_sense
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e mode_i,
  input  logic   en_i,
  input  logic   cur_i,
  input  logic   prev_i,
  input  logic   clr_i,
  output logic   req_o,
  output logic   pend_o
);
  logic rise, fall, hit, pend_q;

  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    unique case (mode_i)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pend_q <= 1'b0;
    else if (en_i && hit)    pend_q <= 1'b1;
    else if (clr_i)          pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign req_o  = en_i & ((mode_i == SENSE_LOW) ? ~cur_i : pend_q);
endmodule

// File: rtl/pin_change.sv
module pin_change #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] prev_i,
  input  logic         clr_i,
  output logic         req_o,
  output logic         pend_o
);
  logic [N-1:0] pin_hit;
  logic         pend_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    assign pin_hit[g] = mask_i[g] & (cur_i[g] ^ prev_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (en_i && |pin_hit)   pend_q <= 1'b1;
    else if (clr_i)              pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign req_o  = en_i & pend_q;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int unsigned NPINS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_pin_i,
  input  logic [NPINS-1:0] grp_pin_i,
  input  logic [1:0]       sense_mode_i,
  input  logic             ext_en_i,
  input  logic             grp_en_i,
  input  logic [NPINS-1:0] grp_mask_i,
  input  logic             ext_clr_i,
  input  logic             grp_clr_i,
  output logic             ext_req_o,
  output logic             grp_req_o,
  output logic             ext_pend_o,
  output logic             grp_pend_o
);
  localparam int unsigned SW = NPINS + 1;

  logic [SW-1:0] raw, cur, prev;

  assign raw = {ext_pin_i, grp_pin_i};

  irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (cur),
    .prev_o (prev)
  );

  ext_sense u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (sense_e'(sense_mode_i)),
    .en_i   (ext_en_i),
    .cur_i  (cur[SW-1]),
    .prev_i (prev[SW-1]),
    .clr_i  (ext_clr_i),
    .req_o  (ext_req_o),
    .pend_o (ext_pend_o)
  );

  pin_change #(.N(NPINS)) u_grp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (grp_en_i),
    .mask_i (grp_mask_i),
    .cur_i  (cur[NPINS-1:0]),
    .prev_i (prev[NPINS-1:0]),
    .clr_i  (grp_clr_i),
    .req_o  (grp_req_o),
    .pend_o (grp_pend_o)
  );
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
  parameter int unsigned NPINS = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_pin_i,
  input logic [NPINS-1:0] grp_pin_i,
  input logic [1:0]       sense_mode_i,
  input logic             ext_en_i,
  input logic             grp_en_i,
  input logic [NPINS-1:0] grp_mask_i,
  input logic             ext_clr_i,
  input logic             grp_clr_i,
  input logic             ext_req_o,
  input logic             grp_req_o,
  input logic             ext_pend_o,
  input logic             grp_pend_o
);
  assert_level_no_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_pend_o) |-> ($past(sense_mode_i) != 2'b00));

  assert_ext_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_pend_o) |-> $past(ext_en_i));

  assert_grp_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grp_pend_o) |-> ($past(grp_en_i) && ($past(grp_mask_i) != '0)));

  assert_ext_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_pend_o) |-> $past(ext_clr_i));

  assert_grp_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grp_pend_o) |-> $past(grp_clr_i));

  assert_ext_req_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_en_i) |-> !ext_req_o);
endmodule

bind ext_irq_unit ext_irq_unit_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/ext_irq_unit_tb_top.sv
module ext_irq_unit_tb_top;
  localparam int NP = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ext_pin = 1'b0;
  logic [NP-1:0] grp_pin = '0;
  logic [1:0]    mode = 2'b00;
  logic          ext_en = 1'b0, grp_en = 1'b0;
  logic [NP-1:0] mask = '0;
  logic          ext_clr = 1'b0, grp_clr = 1'b0;
  logic          ext_req, grp_req, ext_pend, grp_pend;

  int checks = 0;
  int errors = 0;

  ext_irq_unit #(.NPINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .grp_pin_i(grp_pin),
    .sense_mode_i(mode), .ext_en_i(ext_en), .grp_en_i(grp_en), .grp_mask_i(mask),
    .ext_clr_i(ext_clr), .grp_clr_i(grp_clr), .ext_req_o(ext_req), .grp_req_o(grp_req),
    .ext_pend_o(ext_pend), .grp_pend_o(grp_pend)
  );

  // reference model: history of sampled pins, newest first
  logic [NP:0] hist [$] = '{'0, '0, '0};
  logic m_ext_pend = 1'b0, m_grp_pend = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{'0, '0, '0};
      m_ext_pend = 1'b0;
      m_grp_pend = 1'b0;
    end else begin
      logic [NP:0] now, old;
      logic ev_e, ev_g;
      now = hist[1];
      old = hist[2];
      case (mode)
        2'b01:   ev_e = now[NP] != old[NP];
        2'b10:   ev_e = old[NP] && !now[NP];
        2'b11:   ev_e = !old[NP] && now[NP];
        default: ev_e = 1'b0;
      endcase
      ev_e = ev_e && ext_en;
      ev_g = grp_en && (((now[NP-1:0] ^ old[NP-1:0]) & mask) != '0);
      if (ev_e) m_ext_pend = 1'b1; else if (ext_clr) m_ext_pend = 1'b0;
      if (ev_g) m_grp_pend = 1'b1; else if (grp_clr) m_grp_pend = 1'b0;
      hist.push_front({ext_pin, grp_pin});
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    string te, tg;
    logic s2;
    s2 = hist[1][NP];
    if (!ext_en) te = "R6";
    else case (mode)
      2'b00: te = "R2";
      2'b01: te = "R3";
      2'b10: te = "R4";
      default: te = "R5";
    endcase
    if (ext_clr) te = "R9";
    tg = (grp_en && mask != '0) ? "R7" : "R8";
    if (grp_clr) tg = "R9";
    chk(te, "ext_req", ext_req, ext_en & ((mode == 2'b00) ? ~s2 : m_ext_pend));
    chk(te, "ext_pend", ext_pend, m_ext_pend);
    chk(tg, "grp_req", grp_req, grp_en & m_grp_pend);
    chk(tg, "grp_pend", grp_pend, m_grp_pend);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_all();
    ext_clr = 1'b1; grp_clr = 1'b1;
    tick();
    ext_clr = 1'b0; grp_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    logic [15:0] lf;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "ext_req", ext_req, 1'b0);
    chk("R1", "grp_req", grp_req, 1'b0);
    chk("R1", "ext_pend", ext_pend, 1'b0);
    chk("R1", "grp_pend", grp_pend, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "ext_pend_post", ext_pend, 1'b0);

    // R2: low level mode
    ext_en = 1'b1; mode = 2'b00;
    step(1);
    chk("R2", "req_low", ext_req, 1'b1);
    ext_pin = 1'b1;
    tick();
    chk("R2", "req_lag", ext_req, 1'b1);
    tick();
    chk("R2", "req_high", ext_req, 1'b0);
    ext_pin = 1'b0; step(4);
    chk("R2", "no_pend", ext_pend, 1'b0);

    // R3: any change
    mode = 2'b01; step(3);
    ext_pin = 1'b1; step(4);
    chk("R3", "rise_sets", ext_pend, 1'b1);
    clear_all(); step(2);
    ext_pin = 1'b0; step(4);
    chk("R3", "fall_sets", ext_pend, 1'b1);
    clear_all();

    // R4: falling only
    mode = 2'b10; step(2);
    ext_pin = 1'b1; step(4);
    chk("R4", "rise_ignored", ext_pend, 1'b0);
    ext_pin = 1'b0; step(4);
    chk("R4", "fall_sets", ext_pend, 1'b1);
    clear_all();

    // R5: rising only
    mode = 2'b11; step(2);
    ext_pin = 1'b1; step(4);
    chk("R5", "rise_sets", ext_pend, 1'b1);
    clear_all();
    ext_pin = 1'b0; step(4);
    chk("R5", "fall_ignored", ext_pend, 1'b0);

    // R10: latency of edge detection
    ext_pin = 1'b1;
    tick(); chk("R10", "edge1", ext_pend, 1'b0);
    tick(); chk("R10", "edge2", ext_pend, 1'b0);
    tick(); chk("R10", "edge3", ext_pend, 1'b1);
    clear_all();
    ext_pin = 1'b0; step(4);
    clear_all();

    // R6: enable off
    ext_en = 1'b0; mode = 2'b01;
    ext_pin = 1'b1; step(4);
    ext_pin = 1'b0; step(4);
    chk("R6", "no_pend", ext_pend, 1'b0);
    chk("R6", "no_req", ext_req, 1'b0);
    ext_en = 1'b1;

    // R7/R8: pin group
    grp_en = 1'b1; mask = 6'b001100;
    grp_pin[0] = 1'b1; step(4);
    chk("R8", "masked_pin", grp_pend, 1'b0);
    grp_pin[2] = 1'b1; step(4);
    chk("R7", "enabled_pin", grp_pend, 1'b1);
    chk("R7", "req", grp_req, 1'b1);
    clear_all();
    grp_en = 1'b0;
    grp_pin[3] = 1'b1; step(4);
    chk("R8", "global_off", grp_pend, 1'b0);
    grp_en = 1'b1;

    // R9: clear held across event arrival, event wins
    grp_clr = 1'b1; ext_clr = 1'b1;
    grp_pin[3] = 1'b0; ext_pin = 1'b1;
    step(3);
    chk("R9", "grp_event_wins", grp_pend, 1'b1);
    chk("R9", "ext_event_wins", ext_pend, 1'b1);
    tick();
    chk("R9", "grp_cleared", grp_pend, 1'b0);
    grp_clr = 1'b0; ext_clr = 1'b0;

    // mixed pseudo-random stream
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ext_pin = lf[0];
      grp_pin = lf[7:2];
      if (lf[11:9] == 3'b000) mode = lf[5:4];
      ext_en  = lf[12] | lf[1];
      grp_en  = lf[13] | lf[8];
      mask    = lf[15:10];
      ext_clr = lf[14] & lf[3];
      grp_clr = lf[6] & lf[9];
      tick();
    end
    summary();
  end
endmodule